// File: doc/BRIEF.md
# Pointer-Addressed Temperature Register Slave

This block is the serial-bus face of a temperature monitor. It is a two-wire (I2C) slave, and it samples SCL and SDA with the system clock. It recognises START and STOP conditions and answers to a 7-bit address. The upper four bits of that address are fixed, and the lower three come from strap inputs. A write-only pointer register selects one of four registers: the current temperature, the configuration byte, the hysteresis threshold and the setpoint. The first data byte of every write transaction sets the pointer. Because the pointer persists, a read either follows a pointer write through a repeated START or uses the last pointer with a bare address.

The three temperature registers are 16-bit words sent MSB first. The 9-bit two's-complement value (half-degree units) sits in bits 15..7, and bits 6..0 read as zero. The configuration register is a single byte. The setpoint, hysteresis and configuration fields leave the block as plain levels for the alarm logic. A one-cycle pulse reports each completed read transaction, which the alarm logic uses to clear a latched event.

The block has no valid/ready stream at its edge. The bus master paces every transfer, and `temp_i` is a level that is captured when a read begins, so there is no back-pressure to manage. Clock stretching and general-call addressing are not supported.

Top module: `thermo_reg_slave`

## Requirements
- R1: After reset the setpoint reads 9'h0A0 (word 16'h5000), the hysteresis reads 9'h096 (word 16'h4B00), all configuration fields are zero, and the pointer selects the temperature register.
- R2: An address byte is acknowledged only when its upper seven bits equal 1001 followed by `strap_i`. Bit 0 of the address byte is the direction bit, where 1 means read. An address that does not match gets no acknowledge, and the bytes that follow it change nothing.
- R3: Pointer code 2'b11 selects the setpoint and 2'b10 selects the hysteresis. A write to either takes two data bytes, MSB byte first. The 9-bit value is the first byte followed by bit 7 of the second byte.
- R4: Pointer code 2'b01 selects the configuration byte. The first data byte is stored with bit 0 as shutdown, bit 1 as interrupt mode, bit 2 as polarity and bits 4..3 as the fault queue. Bits 7..5 are discarded and read as zero.
- R5: A read of a 16-bit register returns the high byte and then the low byte, each MSB first. Pointer code 2'b00 returns `temp_i` in bits 15..7 with bits 6..0 zero.
- R6: A read that is not preceded by a pointer byte in the same transaction uses the pointer left by the last write.
- R7: A read of the configuration register returns the configuration byte for every byte the master clocks out.
- R8: A write with pointer code 2'b00 is acknowledged, but it changes no register.
- R9: The block acknowledges every byte written after a matched write address, including the pointer byte and bytes beyond the register length.
- R10: `rd_pulse_o` pulses for exactly one cycle when a read transaction that delivered at least one byte ends with STOP or a repeated START. Write transactions produce no pulse.
- R11: A setpoint or hysteresis write that ends after only its first data byte leaves the register unchanged.
- R12: A START at any point, including in the middle of a byte, releases SDA and restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| strap_i | input | 3 | Low three address bits |
| temp_i | input | 9 | Latest converted temperature, two's complement, 0.5 °C units |
| shutdown_o | output | 1 | Configuration: shutdown request |
| int_mode_o | output | 1 | Configuration: 1 selects interrupt mode |
| polarity_o | output | 1 | Configuration: 1 selects an active-high alarm |
| fault_q_o | output | 2 | Configuration: fault queue code |
| tset_o | output | 9 | Setpoint value |
| thyst_o | output | 9 | Hysteresis value |
| rd_pulse_o | output | 1 | One-cycle pulse per completed read transaction |

## Verification
The bench goes after four boundaries.

- **Truncated setpoint write (one data byte, then STOP).** A design that committed each byte as it arrived would corrupt the setpoint.
- **START in the middle of a byte.** A design that did not restart would keep shifting and misread the address.
- **Bare read after a pointer write.** A design that reset the pointer at each transaction would return the temperature instead of the selected register.
- **Configuration read of more than one byte.** A design with a single register length would return zero or garbage in the second byte.

Random write and read transactions with a random temperature are compared against a bench register model. That comparison would catch a swapped byte order, the wrong bit taken from the low byte, or a read pulse that is missing or doubled.

// File: rtl/thermo_reg_pkg.sv
package thermo_reg_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned IDX_W  = 2;

  typedef enum logic [1:0] {
    SEL_TEMP = 2'b00,
    SEL_CFG  = 2'b01,
    SEL_HYST = 2'b10,
    SEL_SET  = 2'b11
  } reg_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } bus_st_e;

  typedef struct packed {
    logic [1:0] fault_q;
    logic       polarity;
    logic       int_mode;
    logic       shutdown;
  } cfg_t;

  localparam int unsigned CFG_W = $bits(cfg_t);

endpackage

// File: rtl/trs_line_sampler.sv
module trs_line_sampler #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [SYNC_STAGES-1:0] scl_pipe;
  logic [SYNC_STAGES-1:0] sda_pipe;
  logic scl_prev, sda_prev;
  logic scl_now, sda_now;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe[0] <= 1'b1;
          sda_pipe[0] <= 1'b1;
        end else begin
          scl_pipe[0] <= scl_i;
          sda_pipe[0] <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else begin
          scl_pipe[g] <= scl_pipe[g-1];
          sda_pipe[g] <= sda_pipe[g-1];
        end
      end
    end
  end

  assign scl_now = scl_pipe[SYNC_STAGES-1];
  assign sda_now = sda_pipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_now;
      sda_prev <= sda_now;
    end
  end

  assign sda_s     = sda_now;
  assign scl_rise  = scl_now & ~scl_prev;
  assign scl_fall  = ~scl_now & scl_prev;
  assign start_det = scl_now & scl_prev & sda_prev & ~sda_now;
  assign stop_det  = scl_now & scl_prev & ~sda_prev & sda_now;

endmodule

// File: rtl/trs_bus_fsm.sv
module trs_bus_fsm
  import thermo_reg_pkg::*;
#(
  parameter int unsigned ADDR_HI_W = 4,
  parameter logic [ADDR_HI_W-1:0] ADDR_HI = 4'b1001,
  parameter int unsigned STRAP_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sda_s,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic [STRAP_W-1:0] strap,
  input  logic [WORD_W-1:0]  rd_word,
  output logic               sda_oe,
  output logic               wbyte_vld,
  output logic [BYTE_W-1:0]  wbyte,
  output logic [IDX_W-1:0]   wbyte_idx,
  output logic               rd_pulse
);

  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  bus_st_e            st;
  logic [CNT_W-1:0]   bit_cnt;
  logic [BYTE_W-1:0]  sh;
  logic               byte_full;
  logic               rw;
  logic [IDX_W-1:0]   byte_idx;
  logic [WORD_W-1:0]  tx_word;
  logic               tx_low_next;
  logic               rd_used;
  logic               master_ack;
  logic               addr_hit;

  assign addr_hit = (sh[BYTE_W-1:1] == {ADDR_HI, strap});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      bit_cnt     <= '0;
      sh          <= '0;
      byte_full   <= 1'b0;
      rw          <= 1'b0;
      byte_idx    <= '0;
      tx_word     <= '0;
      tx_low_next <= 1'b0;
      rd_used     <= 1'b0;
      master_ack  <= 1'b0;
      sda_oe      <= 1'b0;
      wbyte_vld   <= 1'b0;
      wbyte       <= '0;
      wbyte_idx   <= '0;
      rd_pulse    <= 1'b0;
    end else begin
      wbyte_vld <= 1'b0;
      rd_pulse  <= 1'b0;
      if (start_det) begin
        rd_pulse  <= rd_used;
        rd_used   <= 1'b0;
        st        <= ST_ADDR;
        bit_cnt   <= '0;
        byte_full <= 1'b0;
        sda_oe    <= 1'b0;
      end else if (stop_det) begin
        rd_pulse <= rd_used;
        rd_used  <= 1'b0;
        st       <= ST_IDLE;
        sda_oe   <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR, ST_WR: begin
            if (scl_rise) begin
              sh      <= {sh[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
              if (bit_cnt == LAST_BIT) byte_full <= 1'b1;
            end
            if (scl_fall && byte_full) begin
              byte_full <= 1'b0;
              if (st == ST_ADDR) begin
                if (addr_hit) begin
                  sda_oe <= 1'b1;
                  rw     <= sh[0];
                  st     <= ST_ADDR_ACK;
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                sda_oe    <= 1'b1;
                st        <= ST_WR_ACK;
                wbyte_vld <= 1'b1;
                wbyte     <= sh;
                wbyte_idx <= byte_idx;
                if (byte_idx != IDX_MAX) byte_idx <= byte_idx + 1'b1;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (rw) begin
                st          <= ST_RD;
                tx_word     <= rd_word;
                sh          <= rd_word[WORD_W-1 -: BYTE_W];
                sda_oe      <= ~rd_word[WORD_W-1];
                tx_low_next <= 1'b1;
                rd_used     <= 1'b1;
              end else begin
                st       <= ST_WR;
                sda_oe   <= 1'b0;
                byte_idx <= '0;
              end
            end
          end
          ST_WR_ACK: begin
            if (scl_fall) begin
              sda_oe  <= 1'b0;
              st      <= ST_WR;
              bit_cnt <= '0;
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (bit_cnt == LAST_BIT) begin
                sda_oe <= 1'b0;
                st     <= ST_RD_ACK;
              end else begin
                sh      <= {sh[BYTE_W-2:0], 1'b0};
                sda_oe  <= ~sh[BYTE_W-2];
                bit_cnt <= bit_cnt + 1'b1;
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) master_ack <= ~sda_s;
            if (scl_fall) begin
              if (master_ack) begin
                st          <= ST_RD;
                bit_cnt     <= '0;
                tx_low_next <= ~tx_low_next;
                if (tx_low_next) begin
                  sh     <= tx_word[BYTE_W-1:0];
                  sda_oe <= ~tx_word[BYTE_W-1];
                end else begin
                  sh     <= tx_word[WORD_W-1 -: BYTE_W];
                  sda_oe <= ~tx_word[WORD_W-1];
                end
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/trs_reg_bank.sv
module trs_reg_bank
  import thermo_reg_pkg::*;
#(
  parameter int unsigned VAL_W = 9,
  parameter logic [VAL_W-1:0] TSET_RST  = 9'h0A0,
  parameter logic [VAL_W-1:0] THYST_RST = 9'h096,
  parameter logic [CFG_W-1:0] CFG_RST   = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wbyte_vld,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic [IDX_W-1:0]  wbyte_idx,
  input  logic [VAL_W-1:0]  temp_i,
  output logic [WORD_W-1:0] rd_word,
  output cfg_t              cfg,
  output logic [VAL_W-1:0]  tset,
  output logic [VAL_W-1:0]  thyst
);

  localparam int unsigned PAD_W = WORD_W - VAL_W;
  localparam int unsigned LOW_W = VAL_W - BYTE_W;

  reg_sel_e          ptr;
  logic [BYTE_W-1:0] msb_hold;
  logic [VAL_W-1:0]  joined;
  logic [BYTE_W-1:0] cfg_byte;

  assign joined   = {msb_hold, wbyte[BYTE_W-1 -: LOW_W]};
  assign cfg_byte = {{(BYTE_W-CFG_W){1'b0}}, cfg};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr      <= SEL_TEMP;
      msb_hold <= '0;
      cfg      <= cfg_t'(CFG_RST);
      tset     <= TSET_RST;
      thyst    <= THYST_RST;
    end else if (wbyte_vld) begin
      unique case (wbyte_idx)
        2'd0: ptr <= reg_sel_e'(wbyte[1:0]);
        2'd1: begin
          if (ptr == SEL_CFG) cfg <= cfg_t'(wbyte[CFG_W-1:0]);
          else                msb_hold <= wbyte;
        end
        2'd2: begin
          if (ptr == SEL_SET)  tset  <= joined;
          if (ptr == SEL_HYST) thyst <= joined;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (ptr)
      SEL_TEMP: rd_word = {temp_i, {PAD_W{1'b0}}};
      SEL_CFG:  rd_word = {cfg_byte, cfg_byte};
      SEL_HYST: rd_word = {thyst, {PAD_W{1'b0}}};
      default:  rd_word = {tset, {PAD_W{1'b0}}};
    endcase
  end

endmodule

// File: rtl/thermo_reg_slave.sv
module thermo_reg_slave
  import thermo_reg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned VAL_W = 9,
  parameter int unsigned STRAP_W = 3,
  parameter logic [3:0] ADDR_HI = 4'b1001,
  parameter logic [VAL_W-1:0] TSET_RST  = 9'h0A0,
  parameter logic [VAL_W-1:0] THYST_RST = 9'h096
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [VAL_W-1:0]   temp_i,
  output logic               shutdown_o,
  output logic               int_mode_o,
  output logic               polarity_o,
  output logic [1:0]         fault_q_o,
  output logic [VAL_W-1:0]   tset_o,
  output logic [VAL_W-1:0]   thyst_o,
  output logic               rd_pulse_o
);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wbyte_vld;
  logic [BYTE_W-1:0] wbyte;
  logic [IDX_W-1:0]  wbyte_idx;
  logic [WORD_W-1:0] rd_word;
  cfg_t cfg_q;

  trs_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  trs_bus_fsm #(.ADDR_HI_W(4), .ADDR_HI(ADDR_HI), .STRAP_W(STRAP_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .strap(strap_i), .rd_word(rd_word), .sda_oe(sda_oe_o),
    .wbyte_vld(wbyte_vld), .wbyte(wbyte), .wbyte_idx(wbyte_idx),
    .rd_pulse(rd_pulse_o)
  );

  trs_reg_bank #(.VAL_W(VAL_W), .TSET_RST(TSET_RST), .THYST_RST(THYST_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wbyte_vld(wbyte_vld), .wbyte(wbyte),
    .wbyte_idx(wbyte_idx), .temp_i(temp_i), .rd_word(rd_word),
    .cfg(cfg_q), .tset(tset_o), .thyst(thyst_o)
  );

  assign shutdown_o = cfg_q.shutdown;
  assign int_mode_o = cfg_q.int_mode;
  assign polarity_o = cfg_q.polarity;
  assign fault_q_o  = cfg_q.fault_q;

endmodule

// File: rtl/thermo_reg_slave_chk.sv
module thermo_reg_slave_chk #(
  parameter int unsigned VAL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sda_oe,
  input logic             rd_pulse,
  input logic             start_det,
  input logic             stop_det,
  input logic             wbyte_vld,
  input logic [VAL_W-1:0] tset,
  input logic [VAL_W-1:0] thyst,
  input logic [4:0]       cfg_bits
);

  assert_stop_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  assert_start_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !sda_oe);

  assert_tset_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wbyte_vld |=> $stable(tset));

  assert_thyst_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wbyte_vld |=> $stable(thyst));

  assert_cfg_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wbyte_vld |=> $stable(cfg_bits));

  assert_pulse_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pulse |=> !rd_pulse);

  assert_pulse_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pulse |-> $past(start_det || stop_det));

endmodule

bind thermo_reg_slave thermo_reg_slave_chk #(.VAL_W(VAL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe_o), .rd_pulse(rd_pulse_o),
  .start_det(start_det), .stop_det(stop_det), .wbyte_vld(wbyte_vld),
  .tset(tset_o), .thyst(thyst_o), .cfg_bits(cfg_q)
);

// File: tb/thermo_reg_slave_bench.sv
`timescale 1ns/1ps
module thermo_reg_slave_bench;

  localparam int Q = 10;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [8:0] temp_v = 9'h032;
  logic shutdown, int_mode, polarity, rd_pulse;
  logic [1:0] fault_q;
  logic [8:0] tset, thyst;
  wire sda_line = sda_m & ~sda_oe;

  int n_cmp = 0;
  int n_bad = 0;
  int pulse_cnt = 0;
  bit done = 1'b0;

  logic [8:0] m_tset = 9'h0A0;
  logic [8:0] m_thyst = 9'h096;
  logic [4:0] m_cfg = 5'h00;
  logic [1:0] m_ptr = 2'b00;

  always #2.5 clk = ~clk;

  thermo_reg_slave u_thermo_reg_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .strap_i(STRAP), .temp_i(temp_v),
    .shutdown_o(shutdown), .int_mode_o(int_mode), .polarity_o(polarity),
    .fault_q_o(fault_q), .tset_o(tset), .thyst_o(thyst), .rd_pulse_o(rd_pulse)
  );

  always @(posedge clk) if (rd_pulse) pulse_cnt <= pulse_cnt + 1;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input logic [1:0] p);
    case (p)
      2'b00:   return {temp_v, 7'b0};
      2'b01:   return {3'b0, m_cfg, 3'b0, m_cfg};
      2'b10:   return {m_thyst, 7'b0};
      default: return {m_tset, 7'b0};
    endcase
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic bit_cycle(input logic d, output logic s);
    sda_m = d; tick(Q);
    scl_m = 1'b1; tick(Q);
    s = sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
    bit_cycle(1'b1, s);
    ack = ~s;
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(1'b1, s);
      b[i] = s;
    end
    bit_cycle(~give_ack, s);
  endtask

  task automatic check_ports(input string req);
    check(req, tset, m_tset);
    check(req, thyst, m_thyst);
    check(req, {fault_q, polarity, int_mode, shutdown}, m_cfg);
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] ptrb, input int nb,
                          input logic [15:0] d, input string req);
    logic ack;
    logic exp_ack;
    int base;
    base = pulse_cnt;
    exp_ack = (a == STRAP);
    bus_start();
    wr_byte({4'b1001, a, 1'b0}, ack);
    check({req, " R2 addr ack"}, ack, exp_ack);
    wr_byte(ptrb, ack);
    check({req, " R9 ptr ack"}, ack, exp_ack);
    for (int k = 0; k < nb; k++) begin
      wr_byte(k == 0 ? d[15:8] : d[7:0], ack);
      check({req, " R9 data ack"}, ack, exp_ack);
    end
    bus_stop();
    if (exp_ack) begin
      m_ptr = ptrb[1:0];
      if (m_ptr == 2'b01 && nb >= 1) m_cfg = d[12:8];
      if (m_ptr == 2'b11 && nb >= 2) m_tset = {d[15:8], d[7]};
      if (m_ptr == 2'b10 && nb >= 2) m_thyst = {d[15:8], d[7]};
    end
    check({req, " R10 no pulse on write"}, pulse_cnt - base, 0);
    check_ports(req);
  endtask

  task automatic do_read(input logic set_ptr, input logic [1:0] p, input int nb, input string req);
    logic ack;
    logic [7:0] b;
    logic [15:0] w;
    int base;
    base = pulse_cnt;
    if (set_ptr) begin
      bus_start();
      wr_byte({4'b1001, STRAP, 1'b0}, ack);
      check({req, " R2"}, ack, 1'b1);
      wr_byte({6'b0, p}, ack);
      check({req, " R9"}, ack, 1'b1);
      m_ptr = p;
    end
    bus_start();
    wr_byte({4'b1001, STRAP, 1'b1}, ack);
    check({req, " R2 read addr"}, ack, 1'b1);
    w = exp_word(m_ptr);
    for (int k = 0; k < nb; k++) begin
      rd_byte(k != nb - 1, b);
      check(req, b, (k % 2 == 0) ? w[15:8] : w[7:0]);
    end
    bus_stop();
    tick(4);
    check({req, " R10 one pulse"}, pulse_cnt - base, 1);
  endtask

  initial begin
    logic ack;
    logic [7:0] b;
    logic s;
    logic [15:0] w;
    void'($urandom(32'd4242));
    tick(10);
    check("R1 oe idle", sda_oe, 1'b0);
    check("R1 pulse idle", rd_pulse, 1'b0);
    rst_n = 1'b1;
    tick(5);
    check("R1 setpoint", tset, 9'h0A0);
    check("R1 hysteresis", thyst, 9'h096);
    check("R1 config", {fault_q, polarity, int_mode, shutdown}, 5'h00);
    do_read(1'b0, 2'b00, 2, "R1 R5 R6 default pointer TEMP");

    do_write(STRAP, 8'h03, 2, 16'h3D80, "R3 setpoint");
    do_read(1'b1, 2'b11, 2, "R3 R5 setpoint read");
    do_write(STRAP, 8'h02, 2, 16'hE77F, "R3 hysteresis low bits");

    do_write(STRAP, 8'h03, 1, 16'h1100, "R11 truncated setpoint");
    check("R11 setpoint unchanged", tset, {8'h3D, 1'b1});

    do_write(STRAP, 8'h01, 1, 16'hFF00, "R4 config");
    check("R4 config upper discarded", {fault_q, polarity, int_mode, shutdown}, 5'h1F);
    do_read(1'b0, 2'b01, 3, "R6 R7 config bare read");
    do_write(STRAP, 8'h01, 2, 16'h0AFF, "R4 R9 config extra byte");
    check("R4 fields", {fault_q, polarity, int_mode, shutdown}, 5'h0A);

    do_write(STRAP, 8'h00, 2, 16'hFFFF, "R8 TEMP write");
    temp_v = 9'h1CE;
    do_read(1'b0, 2'b00, 2, "R8 R5 TEMP after write");

    do_write(3'b100, 8'h03, 2, 16'h0000, "R2 wrong strap");
    do_write(3'b001, 8'h02, 2, 16'h0000, "R2 wrong strap b");
    do_read(1'b0, 2'b00, 2, "R2 pointer kept");

    bus_start();
    wr_byte({4'b1001, STRAP, 1'b0}, ack);
    check("R12 addr", ack, 1'b1);
    wr_byte(8'h02, ack);
    m_ptr = 2'b10;
    for (int i = 0; i < 4; i++) bit_cycle(1'b0, s);
    bus_start();
    wr_byte({4'b1001, STRAP, 1'b1}, ack);
    check("R12 restart ack", ack, 1'b1);
    w = exp_word(m_ptr);
    rd_byte(1'b1, b); check("R12 hi", b, w[15:8]);
    rd_byte(1'b0, b); check("R12 lo", b, w[7:0]);
    bus_stop();
    check_ports("R12 no change");

    for (int it = 0; it < 24; it++) begin
      int op;
      logic [15:0] d;
      op = int'($urandom % 4);
      d = 16'($urandom);
      temp_v = 9'($urandom);
      case (op)
        0: do_write(STRAP, {6'b0, 1'b1, 1'($urandom)}, 2, d, "R3 random write");
        1: do_write(STRAP, 8'h01, 1, d, "R4 random config");
        2: do_read(1'b1, 2'($urandom), 1 + int'($urandom % 3), "R5 R6 random read");
        default: do_read(1'b0, 2'b00, 2, "R6 random bare read");
      endcase
    end

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule